// File: doc/BRIEF.md
# DSP Host Port Interface Master

This block sits on the host side of a 16-bit host port link and runs transfers toward as many as four DSP slaves. An internal requester presents one request at a time. The request carries the target index, the direction, and a register select: control, address, data with auto-increment, or data without increment. It also carries a 32-bit write word, byte enables and a variant flag. The block turns each request into two half-word bus cycles on the shared data bus. It uses the target's own chip select, a read/write line, an active-low data strobe, a half-word identify line and two control-code lines.

The two supported slave variants differ in two ways. Variant A has an active-high ready and variant B an active-low ready. The two variants also map register selects to different control codes. Each half-word cycle has one setup cycle with the strobe high. The strobe then falls and stays low until the target reports ready, and a programmable number of hold cycles follows. When the strobe is released, read data is captured. After the second half-word a one-cycle done pulse returns the assembled read word.

Alongside the bus sequencer, the block holds one software-controlled reset output per slave. These outputs are asserted by the block's own reset. It also merges the per-slave active-low interrupt inputs through an enable mask into a single host interrupt.

Top module: `hpi_master`

## Requirements
- R1: After reset, all `dsp_rst_n` outputs are 0, all `hcs_n` are 1, `hds_n` is 1, and `busy`, `done` and `host_irq` are 0.
- R2: A request is taken only when `req_valid` is high while the block is idle. Requests presented while `busy` is high cause no bus cycle and no `done` pulse.
- R3: During an access only the addressed slave's `hcs_n` is low. It stays low from the cycle after acceptance through both half-words, and all chip selects are high when idle.
- R4: Each access has two strobe cycles. `hhwil` is 0 in the first and 1 in the second. The first carries word bits 31:16 and the second carries bits 15:0.
- R5: `hrw` is 0 for a write access and 1 for a read access. `hd_oe` is high only during write accesses.
- R6: `req_sel` encodes 0 = control, 1 = address, 2 = data with increment, 3 = data fixed. Variant A (`req_var`=0) drives `hcntl` codes 00, 10, 01, 11 for these selects. Variant B (`req_var`=1) drives 00, 01, 10, 11.
- R7: The target's `hrdy` bit means ready when 1 for variant A and when 0 for variant B. The `hrdy` bits of slaves that are not addressed have no effect.
- R8: Each half-word has one cycle with the strobe high and the chip select low before `hds_n` falls. `hds_n` then stays low until ready is sampled and for HOLD_CYC more cycles, so it is low for (cycles until ready)+HOLD_CYC cycles.
- R9: Read data on `hd_i` is captured in the cycle the strobe is released. `rdata` = {first half, second half} when `done` is high.
- R10: `hbe_n` is ~`req_be`[3:2] in the first half and ~`req_be`[1:0] in the second, but only for variant B writes to a data select. Otherwise it is 11.
- R11: `done` is a single-cycle pulse that follows the end of the second strobe, and `busy` is 0 while `done` is high.
- R12: A cycle with `sw_rst_we` high loads `sw_rst_hold`. Each bit at 1 holds that slave's `dsp_rst_n` low and each bit at 0 releases it, starting on the next cycle.
- R13: `host_irq` is 1 one cycle after any `hint_n` bit is 0 while its `irq_en` bit is 1. It is 0 one cycle after no enabled input is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_dsp | input | IDX_W | Target slave index |
| req_read | input | 1 | 1 = read, 0 = write |
| req_sel | input | 2 | Register select (see R6) |
| req_var | input | 1 | Slave variant: 0 = A, 1 = B |
| req_wdata | input | 2*HW | Write word |
| req_be | input | 2*HW/8 | Byte enables of the write word, active high |
| busy | output | 1 | Access in progress |
| done | output | 1 | Access finished pulse |
| rdata | output | 2*HW | Read word, valid with done |
| hd_o | output | HW | Bus data driven toward slaves |
| hd_oe | output | 1 | Bus output enable |
| hd_i | input | HW | Bus data from slaves |
| hrw | output | 1 | Read/write line |
| hds_n | output | 1 | Active-low data strobe |
| hhwil | output | 1 | Half-word identify |
| hcntl | output | 2 | Control code |
| hbe_n | output | HW/8 | Active-low byte enables |
| hcs_n | output | NUM_DSP | Active-low chip selects |
| hrdy | input | NUM_DSP | Per-slave ready |
| sw_rst_we | input | 1 | Reset-hold write enable |
| sw_rst_hold | input | NUM_DSP | Reset-hold values |
| dsp_rst_n | output | NUM_DSP | Active-low slave resets |
| hint_n | input | NUM_DSP | Active-low slave interrupts |
| irq_en | input | NUM_DSP | Interrupt enable mask |
| host_irq | output | 1 | Merged host interrupt |

## Verification
The bench builds the block with four slaves and HOLD_CYC=2. This makes the hold counter run past its first count and lets every chip-select position and both ready polarities be hit. Slave ready delays of zero and several cycles show that strobe length follows the ready wait exactly. Read patterns differ per half-word, so swapped halves or a capture taken in the wrong cycle show up in `rdata`.

// File: rtl/hpi_pkg.sv
package hpi_pkg;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_ADDR = 2'd1,
    SEL_DINC = 2'd2,
    SEL_DFIX = 2'd3
  } hpi_sel_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETUP  = 2'd1,
    ST_STROBE = 2'd2,
    ST_HOLD   = 2'd3
  } hpi_st_e;

  // control code per slave variant (0 = A, 1 = B)
  function automatic logic [1:0] map_cntl(input logic var_b, input hpi_sel_e sel);
    logic [1:0] code;
    unique case (sel)
      SEL_CTRL: code = 2'b00;
      SEL_ADDR: code = var_b ? 2'b01 : 2'b10;
      SEL_DINC: code = var_b ? 2'b10 : 2'b01;
      default:  code = 2'b11;
    endcase
    return code;
  endfunction

endpackage

// File: rtl/hpi_seq.sv
module hpi_seq
  import hpi_pkg::*;
#(
  parameter int NUM_DSP  = 4,
  parameter int HOLD_CYC = 1,
  parameter int HW       = 16,
  parameter int IDX_W    = 2,
  localparam int WW      = 2 * HW,
  localparam int BEW     = WW / 8,
  localparam int CNT_W   = (HOLD_CYC > 1) ? $clog2(HOLD_CYC) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [IDX_W-1:0] req_dsp,
  input  logic             req_read,
  input  logic [1:0]       req_sel,
  input  logic             req_var,
  input  logic [WW-1:0]    req_wdata,
  input  logic [BEW-1:0]   req_be,
  input  logic             rdy_sel,
  input  logic [HW-1:0]    hd_i,
  output hpi_st_e          st,
  output logic             half,
  output logic [IDX_W-1:0] lat_dsp,
  output logic             lat_read,
  output hpi_sel_e         lat_sel,
  output logic             lat_var,
  output logic [WW-1:0]    lat_wdata,
  output logic [BEW-1:0]   lat_be,
  output logic             done,
  output logic [WW-1:0]    rdata
);

  hpi_st_e          st_q, st_d;
  logic             half_q, half_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             lat_en, cap_en, done_d;
  logic [HW-1:0]    hi_q, lo_q;

  // next state
  always_comb begin
    st_d   = st_q;
    half_d = half_q;
    cnt_d  = cnt_q;
    lat_en = 1'b0;
    cap_en = 1'b0;
    done_d = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (req_valid) begin
          lat_en = 1'b1;
          half_d = 1'b0;
          st_d   = ST_SETUP;
        end
      end
      ST_SETUP: st_d = ST_STROBE;
      ST_STROBE: begin
        if (rdy_sel) begin
          cnt_d = '0;
          st_d  = ST_HOLD;
        end
      end
      default: begin
        if (cnt_q == CNT_W'(HOLD_CYC - 1)) begin
          cap_en = 1'b1;
          if (half_q) begin
            done_d = 1'b1;
            st_d   = ST_IDLE;
          end else begin
            half_d = 1'b1;
            st_d   = ST_SETUP;
          end
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
    endcase
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      half_q <= 1'b0;
      cnt_q  <= '0;
      done   <= 1'b0;
    end else begin
      st_q   <= st_d;
      half_q <= half_d;
      cnt_q  <= cnt_d;
      done   <= done_d;
    end
  end

  // request latch
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_dsp   <= '0;
      lat_read  <= 1'b1;
      lat_sel   <= SEL_CTRL;
      lat_var   <= 1'b0;
      lat_wdata <= '0;
      lat_be    <= '0;
    end else if (lat_en) begin
      lat_dsp   <= req_dsp;
      lat_read  <= req_read;
      lat_sel   <= hpi_sel_e'(req_sel);
      lat_var   <= req_var;
      lat_wdata <= req_wdata;
      lat_be    <= req_be;
    end
  end

  // read capture on strobe release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= '0;
      lo_q <= '0;
    end else if (cap_en) begin
      if (half_q) lo_q <= hd_i;
      else        hi_q <= hd_i;
    end
  end

  assign st    = st_q;
  assign half  = half_q;
  assign rdata = {hi_q, lo_q};

endmodule

// File: rtl/hpi_pins.sv
module hpi_pins
  import hpi_pkg::*;
#(
  parameter int NUM_DSP = 4,
  parameter int HW      = 16,
  parameter int IDX_W   = 2,
  localparam int WW     = 2 * HW,
  localparam int BEW    = WW / 8,
  localparam int HBW    = HW / 8
) (
  input  hpi_st_e          st,
  input  logic             half,
  input  logic [IDX_W-1:0] lat_dsp,
  input  logic             lat_read,
  input  hpi_sel_e         lat_sel,
  input  logic             lat_var,
  input  logic [WW-1:0]    lat_wdata,
  input  logic [BEW-1:0]   lat_be,
  input  logic [NUM_DSP-1:0] hrdy,
  output logic             rdy_sel,
  output logic [HW-1:0]    hd_o,
  output logic             hd_oe,
  output logic             hrw,
  output logic             hds_n,
  output logic             hhwil,
  output logic [1:0]       hcntl,
  output logic [HBW-1:0]   hbe_n,
  output logic [NUM_DSP-1:0] hcs_n
);

  logic               active;
  logic [NUM_DSP-1:0] hit;
  logic [NUM_DSP-1:0] rdy_hit;

  assign active = (st != ST_IDLE);

  for (genvar g = 0; g < NUM_DSP; g++) begin : g_slave
    assign hit[g]     = (lat_dsp == IDX_W'(g));
    assign hcs_n[g]   = !(active && hit[g]);
    assign rdy_hit[g] = hit[g] && (lat_var ? !hrdy[g] : hrdy[g]);
  end

  assign rdy_sel = |rdy_hit;
  assign hds_n   = !((st == ST_STROBE) || (st == ST_HOLD));
  assign hrw     = active ? lat_read : 1'b1;
  assign hhwil   = active && half;
  assign hcntl   = active ? map_cntl(lat_var, lat_sel) : 2'b00;
  assign hd_oe   = active && !lat_read;
  assign hd_o    = half ? lat_wdata[HW-1:0] : lat_wdata[WW-1:HW];

  always_comb begin
    hbe_n = '1;
    if (active && lat_var && !lat_read &&
        ((lat_sel == SEL_DINC) || (lat_sel == SEL_DFIX))) begin
      hbe_n = half ? ~lat_be[HBW-1:0] : ~lat_be[BEW-1:HBW];
    end
  end

endmodule

// File: rtl/hpi_side.sv
module hpi_side #(
  parameter int NUM_DSP = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sw_rst_we,
  input  logic [NUM_DSP-1:0] sw_rst_hold,
  input  logic [NUM_DSP-1:0] hint_n,
  input  logic [NUM_DSP-1:0] irq_en,
  output logic [NUM_DSP-1:0] dsp_rst_n,
  output logic               host_irq
);

  logic [NUM_DSP-1:0] hold_q;
  logic [NUM_DSP-1:0] pend;
  logic               irq_d;

  for (genvar g = 0; g < NUM_DSP; g++) begin : g_rst
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         hold_q[g] <= 1'b1;
      else if (sw_rst_we) hold_q[g] <= sw_rst_hold[g];
    end
    assign dsp_rst_n[g] = !hold_q[g];
    assign pend[g]      = !hint_n[g] && irq_en[g];
  end

  assign irq_d = |pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) host_irq <= 1'b0;
    else        host_irq <= irq_d;
  end

endmodule

// File: rtl/hpi_master.sv
module hpi_master
  import hpi_pkg::*;
#(
  parameter int NUM_DSP  = 4,
  parameter int HOLD_CYC = 1,
  parameter int HW       = 16,
  localparam int IDX_W   = (NUM_DSP > 1) ? $clog2(NUM_DSP) : 1,
  localparam int WW      = 2 * HW,
  localparam int BEW     = WW / 8,
  localparam int HBW     = HW / 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [IDX_W-1:0]   req_dsp,
  input  logic               req_read,
  input  logic [1:0]         req_sel,
  input  logic               req_var,
  input  logic [WW-1:0]      req_wdata,
  input  logic [BEW-1:0]     req_be,
  output logic               busy,
  output logic               done,
  output logic [WW-1:0]      rdata,
  output logic [HW-1:0]      hd_o,
  output logic               hd_oe,
  input  logic [HW-1:0]      hd_i,
  output logic               hrw,
  output logic               hds_n,
  output logic               hhwil,
  output logic [1:0]         hcntl,
  output logic [HBW-1:0]     hbe_n,
  output logic [NUM_DSP-1:0] hcs_n,
  input  logic [NUM_DSP-1:0] hrdy,
  input  logic               sw_rst_we,
  input  logic [NUM_DSP-1:0] sw_rst_hold,
  output logic [NUM_DSP-1:0] dsp_rst_n,
  input  logic [NUM_DSP-1:0] hint_n,
  input  logic [NUM_DSP-1:0] irq_en,
  output logic               host_irq
);

  hpi_st_e          st;
  logic             half;
  logic [IDX_W-1:0] lat_dsp;
  logic             lat_read;
  hpi_sel_e         lat_sel;
  logic             lat_var;
  logic [WW-1:0]    lat_wdata;
  logic [BEW-1:0]   lat_be;
  logic             rdy_sel;

  hpi_seq #(
    .NUM_DSP(NUM_DSP), .HOLD_CYC(HOLD_CYC), .HW(HW), .IDX_W(IDX_W)
  ) i_seq (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_dsp(req_dsp), .req_read(req_read),
    .req_sel(req_sel), .req_var(req_var), .req_wdata(req_wdata), .req_be(req_be),
    .rdy_sel(rdy_sel), .hd_i(hd_i),
    .st(st), .half(half), .lat_dsp(lat_dsp), .lat_read(lat_read),
    .lat_sel(lat_sel), .lat_var(lat_var), .lat_wdata(lat_wdata), .lat_be(lat_be),
    .done(done), .rdata(rdata)
  );

  hpi_pins #(
    .NUM_DSP(NUM_DSP), .HW(HW), .IDX_W(IDX_W)
  ) i_pins (
    .st(st), .half(half), .lat_dsp(lat_dsp), .lat_read(lat_read),
    .lat_sel(lat_sel), .lat_var(lat_var), .lat_wdata(lat_wdata), .lat_be(lat_be),
    .hrdy(hrdy), .rdy_sel(rdy_sel),
    .hd_o(hd_o), .hd_oe(hd_oe), .hrw(hrw), .hds_n(hds_n), .hhwil(hhwil),
    .hcntl(hcntl), .hbe_n(hbe_n), .hcs_n(hcs_n)
  );

  hpi_side #(
    .NUM_DSP(NUM_DSP)
  ) i_side (
    .clk(clk), .rst_n(rst_n),
    .sw_rst_we(sw_rst_we), .sw_rst_hold(sw_rst_hold),
    .hint_n(hint_n), .irq_en(irq_en),
    .dsp_rst_n(dsp_rst_n), .host_irq(host_irq)
  );

  assign busy = (st != ST_IDLE);

endmodule

// File: rtl/hpi_master_chk.sv
module hpi_master_chk #(
  parameter int NUM_DSP = 4,
  parameter int HW      = 16,
  localparam int HBW    = HW / 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               busy,
  input logic               done,
  input logic               hd_oe,
  input logic               hrw,
  input logic               hds_n,
  input logic [HBW-1:0]     hbe_n,
  input logic [NUM_DSP-1:0] hcs_n
);

  // R3
  cs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~hcs_n));

  // R3
  strobe_needs_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hds_n |-> (hcs_n != {NUM_DSP{1'b1}}));

  // R5
  drive_only_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hd_oe |-> !hrw);

  // R10
  be_write_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hbe_n != {HBW{1'b1}}) |-> !hrw);

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R11
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R8
  strobe_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hds_n |=> (hds_n || ($stable(hrw) && $stable(hcs_n))));

endmodule

bind hpi_master hpi_master_chk #(.NUM_DSP(NUM_DSP), .HW(HW)) i_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .hd_oe(hd_oe),
  .hrw(hrw), .hds_n(hds_n), .hbe_n(hbe_n), .hcs_n(hcs_n)
);

// File: tb/test_hpi_master.sv
`timescale 1ns/1ps
module test_hpi_master;

  localparam int NUM_DSP  = 4;
  localparam int HOLD_CYC = 2;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic [1:0]  req_dsp;
  logic        req_read;
  logic [1:0]  req_sel;
  logic        req_var;
  logic [31:0] req_wdata;
  logic [3:0]  req_be;
  logic        busy, done;
  logic [31:0] rdata;
  logic [15:0] hd_o, hd_i;
  logic        hd_oe, hrw, hds_n, hhwil;
  logic [1:0]  hcntl, hbe_n;
  logic [3:0]  hcs_n, hrdy;
  logic        sw_rst_we;
  logic [3:0]  sw_rst_hold, dsp_rst_n, hint_n, irq_en;
  logic        host_irq;

  always #2.5 clk = ~clk;

  hpi_master #(.NUM_DSP(NUM_DSP), .HOLD_CYC(HOLD_CYC)) i_hpi_master (.*);

  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  typedef struct packed {
    logic [1:0]  cs;
    logic        rw;
    logic [1:0]  cntl;
    logic        hw;
    logic [15:0] data;
    logic [1:0]  be;
    logic [7:0]  len;
  } half_t;

  typedef struct packed {
    logic        rd;
    logic [31:0] word;
  } fin_t;

  half_t half_q[$];
  fin_t  fin_q[$];

  // slave model state
  int          rdy_wait = 0;
  logic [31:0] rd_pattern = '0;
  logic [1:0]  tgt_dsp = '0;
  logic        tgt_var = 1'b0;
  logic        rdy_logic = 1'b0;
  int          lowcnt = 0;
  int          done_cnt = 0;
  half_t       seen;

  assign hd_i = hhwil ? rd_pattern[15:0] : rd_pattern[31:16];

  // target ready per its variant; other slaves always show busy (R7)
  always_comb begin
    for (int i = 0; i < NUM_DSP; i++) begin
      if (2'(i) == tgt_dsp) hrdy[i] = tgt_var ? !rdy_logic : rdy_logic;
      else                  hrdy[i] = tgt_var ? 1'b1 : 1'b0;
    end
  end

  function automatic logic [1:0] exp_cntl(input logic vb, input logic [1:0] sel);
    case (sel)
      2'd0: return 2'b00;
      2'd1: return vb ? 2'b01 : 2'b10;
      2'd2: return vb ? 2'b10 : 2'b01;
      default: return 2'b11;
    endcase
  endfunction

  // monitor: bus halves and completions
  always @(negedge clk) begin
    if (rst_n && !hds_n) begin
      lowcnt++;
      seen.rw   = hrw;
      seen.cntl = hcntl;
      seen.hw   = hhwil;
      seen.data = hd_o;
      seen.be   = hbe_n;
      seen.cs   = 2'd0;
      for (int i = 0; i < NUM_DSP; i++) if (!hcs_n[i]) seen.cs = 2'(i);
      chk(hd_oe == !hrw, "R5", "hd_oe vs direction", {31'd0, hd_oe}, {31'd0, !hrw});
    end else if (lowcnt > 0) begin
      if (half_q.size() == 0) begin
        chk(1'b0, "R2", "unexpected strobe", 32'd1, 32'd0);
      end else begin
        half_t e;
        e = half_q.pop_front();
        chk(seen.cs == e.cs, "R3", "chip select", {30'd0, seen.cs}, {30'd0, e.cs});
        chk(seen.rw == e.rw, "R5", "hrw", {31'd0, seen.rw}, {31'd0, e.rw});
        chk(seen.cntl == e.cntl, "R6", "hcntl", {30'd0, seen.cntl}, {30'd0, e.cntl});
        chk(seen.hw == e.hw, "R4", "hhwil", {31'd0, seen.hw}, {31'd0, e.hw});
        chk(seen.be == e.be, "R10", "hbe_n", {30'd0, seen.be}, {30'd0, e.be});
        chk(lowcnt == int'(e.len), "R8", "strobe low cycles", 32'(lowcnt), {24'd0, e.len});
        if (!e.rw) chk(seen.data == e.data, "R4", "write half", {16'd0, seen.data}, {16'd0, e.data});
      end
      lowcnt = 0;
    end
    rdy_logic = (lowcnt > rdy_wait);
    if (rst_n && done) begin
      done_cnt++;
      chk(!busy, "R11", "busy with done", {31'd0, busy}, 32'd0);
      if (fin_q.size() == 0) begin
        chk(1'b0, "R2", "unexpected done", 32'd1, 32'd0);
      end else begin
        fin_t f;
        f = fin_q.pop_front();
        if (f.rd) chk(rdata == f.word, "R9", "read word", rdata, f.word);
      end
    end
  end

  // driver: pushes expectations then launches the request
  task automatic do_req(input logic [1:0] dsp, input bit rd, input logic [1:0] sel,
                        input bit vb, input logic [31:0] wd, input logic [3:0] be,
                        input int w, input bit poke);
    int n0;
    half_t h;
    @(negedge clk);
    tgt_dsp = dsp; tgt_var = vb; rdy_wait = w; rd_pattern = wd;
    for (int k = 0; k < 2; k++) begin
      h.cs   = dsp;
      h.rw   = rd;
      h.cntl = exp_cntl(vb, sel);
      h.hw   = k[0];
      h.data = (k == 0) ? wd[31:16] : wd[15:0];
      h.be   = (vb && !rd && sel[1]) ? ((k == 0) ? ~be[3:2] : ~be[1:0]) : 2'b11;
      h.len  = 8'(w + 1 + HOLD_CYC);
      half_q.push_back(h);
    end
    fin_q.push_back('{rd: rd, word: wd});
    n0 = done_cnt;
    req_valid = 1'b1; req_dsp = dsp; req_read = rd; req_sel = sel;
    req_var = vb; req_wdata = wd; req_be = be;
    @(negedge clk);
    req_valid = 1'b0;
    if (poke) begin
      @(negedge clk);
      req_valid = 1'b1; req_dsp = dsp + 2'd1; req_read = !rd; req_wdata = ~wd;
      @(negedge clk);
      req_valid = 1'b0;
    end
    while (done_cnt == n0) @(negedge clk);
    @(negedge clk);
    chk(hcs_n == 4'hF, "R3", "chip selects idle", {28'd0, hcs_n}, 32'hF);
    if (poke) begin
      repeat (12) @(negedge clk);
      chk(done_cnt == n0 + 1, "R2", "done count with busy request", 32'(done_cnt), 32'(n0 + 1));
    end
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_dsp = '0; req_read = 1'b0; req_sel = '0;
    req_var = 1'b0; req_wdata = '0; req_be = '0;
    sw_rst_we = 1'b0; sw_rst_hold = '0; hint_n = 4'hF; irq_en = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(dsp_rst_n == 4'h0, "R1", "dsp_rst_n", {28'd0, dsp_rst_n}, 32'h0);
    chk(hcs_n == 4'hF, "R1", "hcs_n", {28'd0, hcs_n}, 32'hF);
    chk(hds_n && !busy && !done && !host_irq, "R1", "idle outputs",
        {28'd0, hds_n, busy, done, host_irq}, 32'h8);

    // R12 software reset control
    sw_rst_we = 1'b1; sw_rst_hold = 4'b0101;
    @(negedge clk);
    sw_rst_we = 1'b0; sw_rst_hold = 4'b1111;
    @(negedge clk);
    chk(dsp_rst_n == 4'b1010, "R12", "partial release", {28'd0, dsp_rst_n}, 32'hA);
    chk(dsp_rst_n == 4'b1010, "R12", "held without write enable", {28'd0, dsp_rst_n}, 32'hA);
    sw_rst_we = 1'b1; sw_rst_hold = 4'b0000;
    @(negedge clk);
    sw_rst_we = 1'b0;
    chk(dsp_rst_n == 4'hF, "R12", "full release", {28'd0, dsp_rst_n}, 32'hF);

    // R13 interrupt merge
    hint_n = 4'b1011; irq_en = 4'b0100;
    @(negedge clk);
    chk(host_irq == 1'b1, "R13", "enabled irq", {31'd0, host_irq}, 32'd1);
    irq_en = 4'b1011;
    @(negedge clk);
    chk(host_irq == 1'b0, "R13", "masked irq", {31'd0, host_irq}, 32'd0);
    hint_n = 4'hF;

    // bus accesses: R4 R5 R6 R7 R8 R9 R10 R11
    do_req(2'd0, 1'b0, 2'd1, 1'b0, 32'hA5A5_1234, 4'hF, 0, 1'b0);
    do_req(2'd1, 1'b1, 2'd2, 1'b0, 32'hBEEF_0F0F, 4'hF, 3, 1'b0);
    do_req(2'd2, 1'b0, 2'd2, 1'b1, 32'h1357_9BDF, 4'b1001, 2, 1'b0);
    do_req(2'd3, 1'b1, 2'd1, 1'b1, 32'hCAFE_F00D, 4'hF, 0, 1'b0);
    do_req(2'd3, 1'b0, 2'd3, 1'b1, 32'h0000_FFFF, 4'b0110, 5, 1'b0);
    do_req(2'd0, 1'b1, 2'd0, 1'b1, 32'h7E57_0001, 4'hF, 1, 1'b0);
    do_req(2'd2, 1'b0, 2'd0, 1'b0, 32'h8421_4218, 4'h0, 4, 1'b0);
    do_req(2'd1, 1'b1, 2'd3, 1'b0, 32'h55AA_AA55, 4'hF, 0, 1'b0);
    // R2 request while busy is ignored
    do_req(2'd1, 1'b0, 2'd2, 1'b1, 32'h2468_ACE0, 4'b1100, 2, 1'b1);

    chk(half_q.size() == 0, "R2", "pending halves", 32'(half_q.size()), 32'd0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R11 watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule